// File: doc/BRIEF.md
# NAND Bus Access Phase Sequencer

This block sets the timing of a single read or write access on a NAND-style parallel bus. A client presents a request that carries a direction, a target memory space (common, attribute or I/O), an address and, for writes, a data word. The sequencer then moves through an address setup phase, a command phase in which the active-low command strobe is held low, and a hold phase. At the end it issues a one-cycle done pulse. While the access runs it drives the address, the write data and the data-bus output enable. On reads it captures the bus data on the final strobe cycle.

Each memory space owns four timing counts: setup, command, hold and write high-impedance. All four are loaded through a small configuration write port. On a write, the high-impedance count is measured from the first cycle of the access, independently of the phases. When that count outlasts setup plus command, the command phase is stretched so that the data is on the bus before the strobe releases. Every count is taken from the bank at acceptance, so configuration writes made during an access only affect later ones.

Top module: `nand_phase_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. A request is taken on a cycle with `req_valid` and `req_ready` both high. Its direction, space, address and write data are latched then, and later changes on the request inputs have no effect on the access in progress. `bus_addr` shows the latched address from the first access cycle through the done cycle.
- R2: Access cycle 0 is the first cycle after acceptance. `cmd_n` first goes low in access cycle S, where S is the selected setup count. S = 0 skips the setup phase.
- R3: On a read, `cmd_n` stays low for exactly max(C,1) consecutive cycles, where C is the selected command count.
- R4: `done` is high in the (H+1)-th cycle after `cmd_n` returns high, where H is the selected hold count. H = 0 puts `done` in the first cycle after the strobe ends.
- R5: `done` lasts exactly one cycle, and `req_ready` is high in the cycle after it.
- R6: On a write with high-impedance count Z, `bus_doe` first rises in access cycle Z. It then stays high through the last hold cycle and falls in the done cycle.
- R7: On a write, the last low cycle of `cmd_n` falls in access cycle max(S+max(C,1)-1, Z). The strobe therefore never ends before the data has been driven for at least one cycle.
- R8: On a read, `bus_doe` never rises. `rd_data` takes the value of `bus_din` present in the last low cycle of `cmd_n` and holds it through the done cycle.
- R9: Configuration writes address space code 0 = common, 1 = attribute, 2 = I/O, and field code 0 = setup, 1 = command, 2 = hold, 3 = high-impedance. Writes to space code 3 are ignored. A request with space code 3 uses the common set. Each space keeps its own values.
- R10: A configuration write made during an access does not change that access. It applies from the next accepted request.
- R11: After reset, `req_ready` = 1, `cmd_n` = 1, `bus_doe` = 0 and `done` = 0, and every timing count is 0. A request then produces a one-cycle strobe in access cycle 0 and `done` in access cycle 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_space | input | 2 | Space code of the timing write |
| cfg_field | input | 2 | Field code of the timing write |
| cfg_data | input | CW | Count value to store |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_space | input | 2 | Space code of the access |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| bus_addr | output | AW | Address driven to the bus |
| cmd_n | output | 1 | Active-low command strobe |
| bus_dout | output | DW | Write data driven to the bus |
| bus_doe | output | 1 | Data-bus output enable |
| bus_din | input | DW | Read data from the bus |
| rd_data | output | DW | Captured read data |
| done | output | 1 | One-cycle end-of-access pulse |

## Verification
The bench sweeps setup, command, hold and high-impedance counts through their zero and small values, on both reads and writes. This exposes designs that fail to skip zero-length phases, or that let a zero command count produce no strobe at all. For writes, it chooses high-impedance counts both shorter and longer than setup plus command. A sequencer that ignored the stretch rule would release the strobe before the data enable, and one that counted from the wrong origin would shift the enable edge. Reads are driven with cycle-stamped bus data, so a capture taken one cycle early or late shows up as a wrong value. Further tests cover space code 3, a mid-access configuration write and counts of 200 and more, which catch a mis-routed register bank, early adoption of new timing values and counter truncation.

// File: rtl/nps_pkg.sv
package nps_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_CMD   = 3'd2,
    PH_HOLD  = 3'd3,
    PH_DONE  = 3'd4
  } phase_t;

  localparam int NUM_SPACES = 3;
  localparam int NUM_FIELDS = 4;

  localparam logic [1:0] FLD_SETUP = 2'd0;
  localparam logic [1:0] FLD_CMD   = 2'd1;
  localparam logic [1:0] FLD_HOLD  = 2'd2;
  localparam logic [1:0] FLD_HIZ   = 2'd3;
endpackage

// File: rtl/nps_timing_bank.sv
module nps_timing_bank
  import nps_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    wspace,
  input  logic [1:0]    wfield,
  input  logic [CW-1:0] wdata,
  input  logic [1:0]    rspace,
  output logic [CW-1:0] t_setup,
  output logic [CW-1:0] t_cmd,
  output logic [CW-1:0] t_hold,
  output logic [CW-1:0] t_hiz
);
  localparam int VW = NUM_FIELDS * CW;

  logic [VW-1:0] space_vec [NUM_SPACES];
  logic [1:0]    rsel;
  logic [VW-1:0] sel_vec;

  for (genvar s = 0; s < NUM_SPACES; s++) begin : g_space
    logic [CW-1:0] fld [NUM_FIELDS];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int f = 0; f < NUM_FIELDS; f++) fld[f] <= '0;
      end else if (we && (wspace == 2'(s))) begin
        fld[wfield] <= wdata;
      end
    end

    assign space_vec[s] = {fld[3], fld[2], fld[1], fld[0]};
  end

  // space code 3 has no bank of its own and falls back to the common set
  always_comb begin
    rsel = (rspace < 2'(NUM_SPACES)) ? rspace : 2'd0;
  end

  assign sel_vec = space_vec[rsel];
  assign t_setup = sel_vec[int'(FLD_SETUP)*CW +: CW];
  assign t_cmd   = sel_vec[int'(FLD_CMD)*CW   +: CW];
  assign t_hold  = sel_vec[int'(FLD_HOLD)*CW  +: CW];
  assign t_hiz   = sel_vec[int'(FLD_HIZ)*CW   +: CW];
endmodule

// File: rtl/nps_hiz_timer.sv
module nps_hiz_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          busy,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (busy && (cnt != '0)) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/nps_phase_fsm.sv
module nps_phase_fsm
  import nps_pkg::*;
#(
  parameter int CW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          wr_q,
  input  logic          hiz_expired,
  input  logic [CW-1:0] t_setup,
  input  logic [CW-1:0] t_cmd,
  input  logic [CW-1:0] t_hold,
  input  logic [DW-1:0] bus_din,
  output phase_t        phase,
  output logic [DW-1:0] rd_data
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] cmd_q;
  logic [CW-1:0] hold_q;
  logic          cmd_min_met;
  logic          cmd_can_end;

  function automatic logic [CW-1:0] at_least_one(input logic [CW-1:0] v);
    return (v == '0) ? CW'(1) : v;
  endfunction

  assign cmd_min_met = (cnt <= CW'(1));
  // a write keeps the strobe low until the data enable has been on
  assign cmd_can_end = cmd_min_met && (!wr_q || hiz_expired);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      cmd_q   <= '0;
      hold_q  <= '0;
      rd_data <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            cmd_q  <= t_cmd;
            hold_q <= t_hold;
            if (t_setup != '0) begin
              phase <= PH_SETUP;
              cnt   <= t_setup;
            end else begin
              phase <= PH_CMD;
              cnt   <= at_least_one(t_cmd);
            end
          end
        end
        PH_SETUP: begin
          if (cnt == CW'(1)) begin
            phase <= PH_CMD;
            cnt   <= at_least_one(cmd_q);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        PH_CMD: begin
          if (cmd_can_end) begin
            if (!wr_q) rd_data <= bus_din;
            if (hold_q != '0) begin
              phase <= PH_HOLD;
              cnt   <= hold_q;
            end else begin
              phase <= PH_DONE;
            end
          end else if (!cmd_min_met) begin
            cnt <= cnt - CW'(1);
          end
        end
        PH_HOLD: begin
          if (cnt == CW'(1)) phase <= PH_DONE;
          else               cnt   <= cnt - CW'(1);
        end
        PH_DONE: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
  import nps_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_space,
  input  logic [1:0]    cfg_field,
  input  logic [CW-1:0] cfg_data,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_space,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [AW-1:0] bus_addr,
  output logic          cmd_n,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] rd_data,
  output logic          done
);
  phase_t        phase;
  logic          accept;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [CW-1:0] t_setup, t_cmd, t_hold, t_hiz;
  logic          hiz_expired;
  logic          in_access;

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  nps_timing_bank #(.CW(CW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .wspace  (cfg_space),
    .wfield  (cfg_field),
    .wdata   (cfg_data),
    .rspace  (req_space),
    .t_setup (t_setup),
    .t_cmd   (t_cmd),
    .t_hold  (t_hold),
    .t_hiz   (t_hiz)
  );

  nps_hiz_timer #(.CW(CW)) u_hiz (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (req_write ? t_hiz : '0),
    .busy     (phase != PH_IDLE),
    .expired  (hiz_expired)
  );

  nps_phase_fsm #(.CW(CW), .DW(DW)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .wr_q        (wr_q),
    .hiz_expired (hiz_expired),
    .t_setup     (t_setup),
    .t_cmd       (t_cmd),
    .t_hold      (t_hold),
    .bus_din     (bus_din),
    .phase       (phase),
    .rd_data     (rd_data)
  );

  assign in_access = (phase == PH_SETUP) || (phase == PH_CMD) || (phase == PH_HOLD);
  assign req_ready = (phase == PH_IDLE);
  assign cmd_n     = (phase != PH_CMD);
  assign done      = (phase == PH_DONE);
  assign bus_doe   = wr_q && hiz_expired && in_access;
  assign bus_addr  = addr_q;
  assign bus_dout  = wdata_q;
endmodule

// File: rtl/nps_checker.sv
module nps_checker (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic req_write,
  input logic cmd_n,
  input logic bus_doe,
  input logic done
);
  logic wr_seen;

  always_ff @(posedge clk) begin
    if (rst)                         wr_seen <= 1'b0;
    else if (req_valid && req_ready) wr_seen <= req_write;
  end

  a_r1_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r2_strobe_busy: assert property (@(posedge clk) disable iff (rst)
    !cmd_n |-> !req_ready);

  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r5_ready_after_done: assert property (@(posedge clk) disable iff (rst)
    done |=> req_ready);

  a_r6_doe_drops_at_done: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_doe) |-> done);

  a_r7_data_before_release: assert property (@(posedge clk) disable iff (rst)
    ($rose(cmd_n) && wr_seen) |-> $past(bus_doe));

  a_r8_no_doe_on_read: assert property (@(posedge clk) disable iff (rst)
    bus_doe |-> wr_seen);
endmodule

bind nand_phase_seq nps_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .cmd_n     (cmd_n),
  .bus_doe   (bus_doe),
  .done      (done)
);

// File: tb/sim_nand_phase_seq.sv
module sim_nand_phase_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_space = '0;
  logic [1:0]    cfg_field = '0;
  logic [CW-1:0] cfg_data = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [1:0]    req_space = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [AW-1:0] bus_addr;
  logic          cmd_n;
  logic [DW-1:0] bus_dout;
  logic          bus_doe;
  logic [DW-1:0] bus_din = '0;
  logic [DW-1:0] rd_data;
  logic          done;

  int total = 0;
  int bad = 0;
  int tm [4][4];

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_phase_seq #(.AW(AW), .DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_space(cfg_space),
    .cfg_field(cfg_field), .cfg_data(cfg_data), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_space(req_space),
    .req_addr(req_addr), .req_wdata(req_wdata), .bus_addr(bus_addr),
    .cmd_n(cmd_n), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .rd_data(rd_data), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int sp, input int fld, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_space = 2'(sp); cfg_field = 2'(fld); cfg_data = CW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    if (sp < 3) tm[sp][fld] = val % 256;
  endtask

  task automatic set_space(input int sp, input int s, input int c, input int h, input int z);
    cfg_write(sp, 0, s);
    cfg_write(sp, 1, c);
    cfg_write(sp, 2, h);
    cfg_write(sp, 3, z);
  endtask

  task automatic do_access(input bit wr, input int sp, input int a, input int wd, input bit mid);
    int esp, s, c, h, z, l, tend, done_e, doe_e;
    int cmd_first, cmd_len, doe_first, doe_len, done_t, done_cnt, addr_bad, dout_bad;
    bit ready_after;
    int rd_seen;
    esp = (sp == 3) ? 0 : sp;
    s = tm[esp][0]; c = tm[esp][1]; h = tm[esp][2]; z = tm[esp][3];
    l = (c == 0) ? 1 : c;
    tend = s + l - 1;
    if (wr && z > tend) tend = z;
    done_e = tend + h + 1;
    doe_e = wr ? (done_e - z) : 0;
    cmd_first = -1; cmd_len = 0; doe_first = -1; doe_len = 0;
    done_t = -1; done_cnt = 0; addr_bad = 0; dout_bad = 0; ready_after = 1'b0; rd_seen = -1;

    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_space = 2'(sp);
    req_addr = AW'(a); req_wdata = DW'(wd);
    @(negedge clk);
    // request inputs scrambled once taken (R1)
    req_valid = 1'b0; req_write = !wr; req_space = ~2'(sp);
    req_addr = ~AW'(a); req_wdata = ~DW'(wd);
    for (int t = 0; t < 3000; t++) begin
      if (t == 0 && mid) begin
        cfg_we = 1'b1; cfg_space = 2'(esp); cfg_field = 2'd0; cfg_data = CW'((s + 1) % 256);
      end
      if (t == 1) cfg_we = 1'b0;
      if (done_t >= 0 && t == done_t + 1) begin
        ready_after = req_ready;
        break;
      end
      if (!cmd_n) begin
        if (cmd_first < 0) cmd_first = t;
        cmd_len++;
      end
      if (bus_doe) begin
        if (doe_first < 0) doe_first = t;
        doe_len++;
        if (bus_dout != DW'(wd)) dout_bad++;
      end
      if (done) begin
        if (done_t < 0) begin
          done_t = t;
          rd_seen = int'(rd_data);
        end
        done_cnt++;
      end
      if (bus_addr != AW'(a)) addr_bad++;
      bus_din = DW'(t);
      @(negedge clk);
    end
    cfg_we = 1'b0;
    if (mid) tm[esp][0] = (s + 1) % 256;

    chk(addr_bad == 0, "R1 address held from latch", addr_bad, 0);
    chk(cmd_first == s, "R2 strobe start cycle", cmd_first, s);
    if (!wr) chk(cmd_len == l, "R3 read strobe length", cmd_len, l);
    else     chk(cmd_len == tend - s + 1, "R7 write strobe length", cmd_len, tend - s + 1);
    chk(done_t == done_e, "R4 done cycle after hold", done_t, done_e);
    chk(done_cnt == 1, "R5 done pulse width", done_cnt, 1);
    chk(ready_after == 1'b1, "R5 ready after done", int'(ready_after), 1);
    chk(doe_len == doe_e, "R6 R8 data enable length", doe_len, doe_e);
    if (wr) begin
      chk(doe_first == z, "R6 data enable start", doe_first, z);
      chk(dout_bad == 0, "R1 write data latched", dout_bad, 0);
    end else begin
      chk(rd_seen == (tend % 256), "R8 read capture", rd_seen, tend % 256);
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++) tm[i][j] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 reset ready", int'(req_ready), 1);
    chk(cmd_n == 1'b1, "R11 reset strobe", int'(cmd_n), 1);
    chk(bus_doe == 1'b0, "R11 reset enable", int'(bus_doe), 0);
    chk(done == 1'b0, "R11 reset done", int'(done), 0);
    // zero counts straight after reset (R11)
    do_access(1'b0, 0, 16'h1234, 8'h00, 1'b0);
    do_access(1'b1, 2, 16'h00F0, 8'hA5, 1'b0);

    // write sweep, space rotates
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 3; c++)
        for (int h = 0; h < 3; h++)
          for (int z = 0; z < 7; z++) begin
            int sp;
            sp = (s + c + h + z) % 3;
            set_space(sp, s, c, h, z);
            do_access(1'b1, sp, 16'h1000 + s*64 + c*16 + h*4 + z, (s*37 + z) % 256, 1'b0);
          end

    // read sweep
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 4; c++)
        for (int h = 0; h < 3; h++) begin
          int sp;
          sp = (s + c + h) % 3;
          set_space(sp, s, c, h, (s + c) % 5);
          do_access(1'b0, sp, 16'h8000 + s*16 + c*4 + h, 0, 1'b0);
        end

    // separate banks per space and space code 3 (R9)
    set_space(0, 1, 2, 1, 0);
    set_space(1, 3, 1, 2, 6);
    set_space(2, 0, 4, 0, 2);
    cfg_write(3, 0, 9);
    cfg_write(3, 1, 9);
    do_access(1'b0, 3, 16'h3333, 0, 1'b0);
    do_access(1'b1, 3, 16'h3334, 8'h3C, 1'b0);
    do_access(1'b1, 1, 16'h1111, 8'h11, 1'b0);
    do_access(1'b0, 2, 16'h2222, 0, 1'b0);
    chk(tm[0][0] == 1, "R9 space 3 write ignored model", tm[0][0], 1);

    // configuration during an access (R10): old setup now, new setup next
    do_access(1'b0, 1, 16'h4444, 0, 1'b1);
    do_access(1'b0, 1, 16'h4445, 0, 1'b0);
    do_access(1'b1, 2, 16'h4446, 8'h5A, 1'b1);
    do_access(1'b1, 2, 16'h4447, 8'h5B, 1'b0);

    // large counts
    set_space(1, 200, 255, 255, 250);
    do_access(1'b1, 1, 16'hBEEF, 8'hC3, 1'b0);
    set_space(2, 10, 20, 30, 255);
    do_access(1'b1, 2, 16'hCAFE, 8'h7E, 1'b0);
    do_access(1'b0, 1, 16'hFACE, 0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R5 actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule